// File: doc/BRIEF.md
# Complement-Accumulate Decimal Divider

This block divides an unsigned decimal number of up to eight BCD digits by a divisor of up to three BCD digits. It suits divisors that sit just under a power of ten. It never subtracts a trial multiple of the divisor. Instead it takes the divisor's complement to the next power of ten, called the deficit. It sweeps the dividend one decimal column per clock. Each finished quotient column total is multiplied by the deficit digits, and the products are folded into the columns that follow.

The rightmost columns, as many as the divisor has significant digits, collect the raw remainder. The leftmost columns collect the raw quotient. Column totals are kept as plain binary integers. They are carried into positional weight only after every column is complete. The raw remainder may still be no smaller than the divisor. A fixed-length correction pass therefore divides it again: the sub-quotient is added to the quotient, and the sub-remainder becomes the result. A zero divisor completes at once with an error flag.

A caller presents both operands with a one-cycle start pulse while the block is idle. It waits for the one-cycle done pulse and then reads the quotient and remainder. These hold their values until the next completion.

Top module: `dcd_divider`

## Requirements
- R1: For any nonzero divisor D and dividend N, at the done pulse the quotient output times D plus the remainder output equals N, and the remainder is less than D. Both outputs are packed BCD with the least significant digit in bits [3:0], and every nibble is in the range 0 to 9.
- R2: done is high for exactly one clock cycle per accepted start.
- R3: A start with an all-zero divisor raises done one cycle after the start edge, with the error flag set. The quotient and remainder outputs keep their previous values.
- R4: A start with a nonzero divisor raises done 44 rising clock edges after the start edge is sampled, counting that edge as the first. The 44 edges are 1 + 2 × 8 + 27, where 27 is the binary width of an eight-digit value.
- R5: A successful division clears an error flag left by an earlier zero-divisor request.
- R6: A start pulse that arrives while a division is running has no effect. The running result and its timing are unchanged.
- R7: A divisor with leading zero digits (one or two significant digits) is handled by using only its significant digits for the deficit and for the size of the remainder part.
- R8: When the complement accumulation leaves a raw remainder at or above the divisor, the correction pass still yields the exact quotient and remainder. Divisors 1, 10 and 100 are cases where this happens.
- R9: After reset, done and error are low and the quotient and remainder outputs are zero.
- R10: Quotient, remainder and error change only on the edge that raises done. In every other cycle they are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| dividend_i | input | 32 | Dividend, eight packed BCD digits |
| divisor_i | input | 12 | Divisor, three packed BCD digits |
| quotient_o | output | 32 | Quotient, eight packed BCD digits |
| remainder_o | output | 12 | Remainder, three packed BCD digits |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set when the last request had a zero divisor |

## Verification
The assertions check four things on every cycle:
- done never lasts longer than one cycle.
- The result nibbles are legal decimal digits whenever a successful result is flagged.
- A zero-divisor completion leaves the previous result untouched.
- Quotient, remainder and error stay frozen outside the completion cycle.

The arithmetic identity and the remainder bound can only be shown by the bench's scenarios, which compare against quotients computed independently. The same holds for the exact 44-edge latency, for divisors with leading zeros, and for the correction of oversized raw remainders. Whether a start pulse during a running division is ignored is also only visible from the scenarios.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_NORM,
    ST_CORR,
    ST_DONE
  } dcd_state_e;

  // Integer power of ten, used for widths and digit extraction.
  function automatic int unsigned pow10(input int unsigned e);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/dcd_deficit_gen.sv
// Derives significant digit count, binary value and complement digits of the divisor.
module dcd_deficit_gen #(
  parameter int DSR_DIGITS = 3,
  localparam int DSR_W = 4 * DSR_DIGITS,
  localparam int DSR_BW = $clog2(dcd_pkg::pow10(DSR_DIGITS)),
  localparam int SIG_W = $clog2(DSR_DIGITS + 1)
) (
  input  logic [DSR_W-1:0]  dsr_bcd_i,
  output logic [SIG_W-1:0]  sig_o,
  output logic [DSR_W-1:0]  def_o,   // slot j-1 holds the j-th complement digit from the top
  output logic [DSR_BW-1:0] dsr_bin_o
);

  int unsigned acc;
  logic [3:0]  dig;

  always_comb begin
    sig_o = '0;
    for (int i = 0; i < DSR_DIGITS; i++) begin
      if (dsr_bcd_i[4*i +: 4] != 4'd0) sig_o = SIG_W'(i + 1);
    end

    def_o = '0;
    dig   = '0;
    for (int j = 1; j <= DSR_DIGITS; j++) begin
      if (j <= int'(sig_o)) begin
        dig = dsr_bcd_i[4*(int'(sig_o) - j) +: 4];
        if (j == int'(sig_o)) def_o[4*(j-1) +: 4] = 4'd10 - dig;
        else                  def_o[4*(j-1) +: 4] = 4'd9 - dig;
      end
    end

    acc = 0;
    for (int i = DSR_DIGITS - 1; i >= 0; i--) begin
      acc = acc * 10 + 32'(dsr_bcd_i[4*i +: 4]);
    end
    dsr_bin_o = DSR_BW'(acc);
  end

endmodule

// File: rtl/dcd_column_sum.sv
// Total for one column: its dividend digit plus deficit-weighted earlier quotient columns.
module dcd_column_sum #(
  parameter int DIVD_DIGITS = 8,
  parameter int DSR_DIGITS  = 3,
  parameter int COL_W       = 31,
  localparam int IDX_W = $clog2(DIVD_DIGITS),
  localparam int SIG_W = $clog2(DSR_DIGITS + 1)
) (
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [SIG_W-1:0]                  sig_i,
  input  logic [4*DSR_DIGITS-1:0]           def_i,
  input  logic [DIVD_DIGITS-1:0][COL_W-1:0] cols_i,
  input  logic [3:0]                        digit_i,
  output logic [COL_W-1:0]                  col_o
);

  int         qcols;
  int         src;
  logic [COL_W-1:0] term;

  always_comb begin
    qcols = DIVD_DIGITS - int'(sig_i);
    col_o = COL_W'(digit_i);
    term  = '0;
    for (int j = 1; j <= DSR_DIGITS; j++) begin
      src = int'(idx_i) - j;
      if (j <= int'(sig_i) && src >= 0 && src < qcols) begin
        term  = cols_i[src] * COL_W'(def_i[4*(j-1) +: 4]);
        col_o = col_o + term;
      end
    end
  end

endmodule

// File: rtl/dcd_fix_step.sv
// One restoring step of the correction pass.
module dcd_fix_step #(
  parameter int DSR_BW = 10
) (
  input  logic [DSR_BW-1:0] part_i,
  input  logic              bit_i,
  input  logic [DSR_BW-1:0] dsr_i,
  output logic [DSR_BW-1:0] part_o,
  output logic              qbit_o
);

  logic [DSR_BW:0] trial;
  logic [DSR_BW:0] diff;

  always_comb begin
    trial = {part_i, bit_i};
    diff  = trial - {1'b0, dsr_i};
    if (trial >= {1'b0, dsr_i}) begin
      qbit_o = 1'b1;
      part_o = diff[DSR_BW-1:0];
    end else begin
      qbit_o = 1'b0;
      part_o = trial[DSR_BW-1:0];
    end
  end

endmodule

// File: rtl/dcd_divider.sv
module dcd_divider #(
  parameter int DIVD_DIGITS = 8,
  parameter int DSR_DIGITS  = 3,
  localparam int DIVD_W = 4 * DIVD_DIGITS,
  localparam int DSR_W  = 4 * DSR_DIGITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIVD_W-1:0] dividend_i,
  input  logic [DSR_W-1:0]  divisor_i,
  output logic [DIVD_W-1:0] quotient_o,
  output logic [DSR_W-1:0]  remainder_o,
  output logic              done_o,
  output logic              err_o
);
  import dcd_pkg::*;

  localparam int DIVD_BW = $clog2(pow10(DIVD_DIGITS));
  localparam int DSR_BW  = $clog2(pow10(DSR_DIGITS));
  localparam int COL_W   = DIVD_BW + 4;
  localparam int IDX_W   = $clog2(DIVD_DIGITS);
  localparam int SIG_W   = $clog2(DSR_DIGITS + 1);
  localparam int CNT_W   = $clog2(DIVD_BW) + 1;

  dcd_state_e state_q, state_d;
  logic [CNT_W-1:0]                  cnt_q, cnt_d;
  logic [DIVD_W-1:0]                 dvd_q;
  logic [DSR_W-1:0]                  dsr_q;
  logic [DIVD_DIGITS-1:0][COL_W-1:0] cols_q;
  logic [DIVD_BW-1:0]                qacc_q, shreg_q;
  logic [DSR_BW-1:0]                 part_q;
  logic [DIVD_W-1:0]                 quo_q;
  logic [DSR_W-1:0]                  rem_q;
  logic                              err_q;

  logic [SIG_W-1:0]  sig;
  logic [DSR_W-1:0]  def_dig;
  logic [DSR_BW-1:0] dsr_bin;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        cur_digit;
  logic [COL_W-1:0]  col_new, col_cur;
  logic              in_quot;
  logic [DSR_BW-1:0] part_nx;
  logic              qbit;
  logic [DIVD_BW-1:0] subq, qfin;
  logic [DIVD_W-1:0] qfin_bcd;
  logic [DSR_W-1:0]  rfin_bcd;
  logic              launch, launch_ok, launch_bad, last_cnt_col, last_cnt_corr;

  assign idx           = cnt_q[IDX_W-1:0];
  assign launch        = (state_q == ST_IDLE) && start_i;
  assign launch_ok     = launch && (divisor_i != '0);
  assign launch_bad    = launch && (divisor_i == '0);
  assign last_cnt_col  = (cnt_q == CNT_W'(DIVD_DIGITS - 1));
  assign last_cnt_corr = (cnt_q == CNT_W'(DIVD_BW - 1));

  dcd_deficit_gen #(.DSR_DIGITS(DSR_DIGITS)) u_def (
    .dsr_bcd_i (dsr_q),
    .sig_o     (sig),
    .def_o     (def_dig),
    .dsr_bin_o (dsr_bin)
  );

  always_comb begin
    cur_digit = dvd_q[4*(DIVD_DIGITS - 1 - int'(idx)) +: 4];
    col_cur   = cols_q[idx];
    in_quot   = int'(idx) < (DIVD_DIGITS - int'(sig));
  end

  dcd_column_sum #(
    .DIVD_DIGITS (DIVD_DIGITS),
    .DSR_DIGITS  (DSR_DIGITS),
    .COL_W       (COL_W)
  ) u_col (
    .idx_i   (idx),
    .sig_i   (sig),
    .def_i   (def_dig),
    .cols_i  (cols_q),
    .digit_i (cur_digit),
    .col_o   (col_new)
  );

  dcd_fix_step #(.DSR_BW(DSR_BW)) u_fix (
    .part_i (part_q),
    .bit_i  (shreg_q[DIVD_BW-1]),
    .dsr_i  (dsr_bin),
    .part_o (part_nx),
    .qbit_o (qbit)
  );

  assign subq = {shreg_q[DIVD_BW-2:0], qbit};
  assign qfin = qacc_q + subq;

  for (genvar g = 0; g < DIVD_DIGITS; g++) begin : g_qbcd
    assign qfin_bcd[4*g +: 4] = 4'((qfin / DIVD_BW'(pow10(g))) % DIVD_BW'(10));
  end
  for (genvar g = 0; g < DSR_DIGITS; g++) begin : g_rbcd
    assign rfin_bcd[4*g +: 4] = 4'((part_nx / DSR_BW'(pow10(g))) % DSR_BW'(10));
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cnt_d   = '0;
        state_d = (divisor_i == '0) ? ST_DONE : ST_ACCUM;
      end
      ST_ACCUM: if (last_cnt_col) begin
        cnt_d = '0; state_d = ST_NORM;
      end else cnt_d = cnt_q + 1'b1;
      ST_NORM: if (last_cnt_col) begin
        cnt_d = '0; state_d = ST_CORR;
      end else cnt_d = cnt_q + 1'b1;
      ST_CORR: if (last_cnt_corr) begin
        cnt_d = '0; state_d = ST_DONE;
      end else cnt_d = cnt_q + 1'b1;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dvd_q   <= '0;
      dsr_q   <= '0;
      cols_q  <= '0;
      qacc_q  <= '0;
      shreg_q <= '0;
      part_q  <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (launch_ok) begin
        dvd_q   <= dividend_i;
        dsr_q   <= divisor_i;
        qacc_q  <= '0;
        shreg_q <= '0;
        part_q  <= '0;
      end
      if (launch_bad) err_q <= 1'b1;
      if (state_q == ST_ACCUM) cols_q[idx] <= col_new;
      if (state_q == ST_NORM && in_quot)
        qacc_q <= qacc_q * DIVD_BW'(10) + DIVD_BW'(col_cur);
      if (state_q == ST_NORM && !in_quot)
        shreg_q <= shreg_q * DIVD_BW'(10) + DIVD_BW'(col_cur);
      if (state_q == ST_CORR) begin
        shreg_q <= subq;
        part_q  <= part_nx;
      end
      if (state_q == ST_CORR && last_cnt_corr) begin
        quo_q <= qfin_bcd;
        rem_q <= rfin_bcd;
        err_q <= 1'b0;
      end
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;

endmodule

// File: rtl/dcd_divider_chk.sv
module dcd_divider_chk #(
  parameter int DIVD_DIGITS = 8,
  parameter int DSR_DIGITS  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [4*DIVD_DIGITS-1:0] quotient_o,
  input logic [4*DSR_DIGITS-1:0]  remainder_o,
  input logic                     done_o,
  input logic                     err_o
);

  logic digits_ok;

  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < DIVD_DIGITS; i++)
      if (quotient_o[4*i +: 4] > 4'd9) digits_ok = 1'b0;
    for (int i = 0; i < DSR_DIGITS; i++)
      if (remainder_o[4*i +: 4] > 4'd9) digits_ok = 1'b0;
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_bcd_digits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> digits_ok);

  assert_err_keeps_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(err_o)));

endmodule

bind dcd_divider dcd_divider_chk #(
  .DIVD_DIGITS (DIVD_DIGITS),
  .DSR_DIGITS  (DSR_DIGITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/dcd_divider_test.sv
module dcd_divider_test;

  localparam int LAT_OK = 44;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] dividend_i;
  logic [11:0] divisor_i;
  logic [31:0] quotient_o;
  logic [11:0] remainder_o;
  logic        done_o;
  logic        err_o;

  int n_checks = 0;
  int n_errors = 0;

  dcd_divider uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] to_bcd(input longint v);
    logic [31:0] r;
    longint      t;
    r = '0;
    t = v;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic launch(input longint n, input longint d);
    @(negedge clk);
    dividend_i = to_bcd(n);
    divisor_i  = 12'(to_bcd(d));
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic wait_done(inout int lat);
    while (!done_o && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic divide_and_check(input string req, input longint n, input longint d);
    int lat;
    launch(n, d);
    lat = 1;
    wait_done(lat);
    check({req, " latency R4"}, lat, LAT_OK);
    check({req, " quotient"}, quotient_o, to_bcd(n / d));
    check({req, " remainder"}, remainder_o, 12'(to_bcd(n % d)));
    check({req, " err low"}, err_o, 0);
  endtask

  task automatic test_reset();
    check("R9 done", done_o, 0);
    check("R9 err", err_o, 0);
    check("R9 quotient", quotient_o, 0);
    check("R9 remainder", remainder_o, 0);
  endtask

  task automatic test_near_power();
    divide_and_check("R1 97", 12345678, 97);
    divide_and_check("R1 998", 99999999, 998);
    divide_and_check("R1 89", 31415926, 89);
    divide_and_check("R1 zero dividend", 0, 89);
    divide_and_check("R1 small dividend", 998, 999);
  endtask

  task automatic test_short_divisor();
    divide_and_check("R7 nine", 7777777, 9);
    divide_and_check("R7 eight", 53, 8);
    divide_and_check("R7 two digit", 86420135, 47);
  endtask

  task automatic test_correction();
    divide_and_check("R8 hundred", 99999999, 100);
    divide_and_check("R8 ten", 4567890, 10);
    divide_and_check("R8 one", 12345678, 1);
    divide_and_check("R8 five hundred", 88888888, 501);
  endtask

  task automatic test_zero_divisor();
    logic [31:0] q_prev;
    logic [11:0] r_prev;
    int          lat;
    q_prev = quotient_o;
    r_prev = remainder_o;
    launch(5555, 0);
    lat = 1;
    wait_done(lat);
    check("R3 latency", lat, 1);
    check("R3 err", err_o, 1);
    check("R3 quotient kept", quotient_o, q_prev);
    check("R3 remainder kept", remainder_o, r_prev);
  endtask

  task automatic test_err_clear();
    divide_and_check("R5 after error", 2468, 99);
  endtask

  task automatic test_busy_start();
    int lat;
    launch(76543210, 97);
    lat = 1;
    repeat (3) begin @(negedge clk); lat++; end
    dividend_i = to_bcd(11111111);
    divisor_i  = 12'(to_bcd(3));
    start_i    = 1'b1;
    @(negedge clk);
    lat++;
    start_i    = 1'b0;
    wait_done(lat);
    check("R6 latency", lat, LAT_OK);
    check("R6 quotient", quotient_o, to_bcd(76543210 / 97));
    check("R6 remainder", remainder_o, 12'(to_bcd(76543210 % 97)));
    @(negedge clk);
    check("R6 no second done", done_o, 0);
  endtask

  task automatic test_pulse_hold();
    logic [31:0] q_seen;
    logic [11:0] r_seen;
    int          lat;
    launch(65432100, 993);
    lat = 1;
    wait_done(lat);
    q_seen = quotient_o;
    r_seen = remainder_o;
    check("R1 993 quotient", q_seen, to_bcd(65432100 / 993));
    @(negedge clk);
    check("R2 done single cycle", done_o, 0);
    repeat (4) @(negedge clk);
    check("R10 quotient held", quotient_o, q_seen);
    check("R10 remainder held", remainder_o, r_seen);
    check("R10 done stays low", done_o, 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    start_i    = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_near_power();
    test_short_divisor();
    test_correction();
    test_zero_divisor();
    test_err_clear();
    test_busy_start();
    test_pulse_hold();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule